// File: doc/BRIEF.md
# Priority Interrupt Vector Arbiter

This block holds interrupt requests from many sources, organised as priority levels with a fixed number of request lines per level. Each request pulse sets a sticky pending bit. The block continuously compares the pending bits with the processor's current priority. It drives a single pending flag whenever some request could be taken. When the processor issues an acknowledge strobe, the block picks one winner and clears that winner's pending bit. One clock later it returns the winner's vector together with a one-cycle valid pulse.

Vectors normally come from a table that is written through a simple write port. A source can also supply its own vector when it wins; this override is enabled per source and sampled with the acknowledge. One reserved bit on each non-zero level carries software requests, and every software request returns the same common vector. A mode input selects restricted-bus behaviour. In that mode, once the processor priority reaches a threshold, only the sources flagged as internal on a per-source mask can take part.

Top module: `irq_vec_arb`

## Requirements
- R1: A request pulse on `req_set_i` (flat index = level*REQ_W + line) sets that pending bit. The bit stays set until it is granted, and it is zero after reset.
- R2: `pend_o` is high exactly when some pending bit is eligible. A bit is eligible when its level is strictly greater than `ipl_i` and the R7 masking lets it through. With `ipl_i` at the top level, `pend_o` is low.
- R3: Among eligible requests, the highest level wins.
- R4: Within the winning level, the lowest-numbered line wins.
- R5: An `ack_i` in cycle n produces `ack_valid_o` high in cycle n+1, with the winner's vector on `ack_vec_o`. The winner's pending bit is clear from cycle n+1 on.
- R6: An `ack_i` with no eligible request returns vector 0 with the valid pulse and clears nothing.
- R7: When `restrict_i` is 1 and `ipl_i` >= HMIN_LVL (default 4), only bits whose `int_mask_i` bit is 1 are eligible. Otherwise every pending bit at an eligible level counts.
- R8: A table write (`tbl_we_i`, level, line, vector) stores the vector with bit 0 forced to 0. A write takes effect for acknowledges in later cycles.
- R9: If the winner's `ovr_en_i` bit is 1, the returned vector is `ovr_vec_i` as sampled with the acknowledge. The table is not used in that case.
- R10: `sw_req_i[l]` for l >= 1 sets pending line SW_BIT (default 31) at level l, and `sw_req_i[0]` has no effect. A winner at line SW_BIT on a level >= 1 returns SW_VEC (default 0x00A0) unless an override applies.
- R11: A request pulse arriving in the same cycle as the grant of that same bit leaves the bit pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | NUM_LVL*REQ_W | Request set pulses, one per source |
| sw_req_i | input | NUM_LVL | Software request pulse per level (bit 0 unused) |
| ipl_i | input | $clog2(NUM_LVL) | Current processor priority |
| restrict_i | input | 1 | 1 selects restricted-bus masking |
| int_mask_i | input | NUM_LVL*REQ_W | Internal-source mask used in restricted mode |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_lvl_i | input | $clog2(NUM_LVL) | Table write level |
| tbl_bit_i | input | $clog2(REQ_W) | Table write line |
| tbl_vec_i | input | VEC_W | Table write data |
| ovr_en_i | input | NUM_LVL*REQ_W | Per-source vector override enable |
| ovr_vec_i | input | VEC_W | Override vector, sampled with ack |
| ack_i | input | 1 | Acknowledge strobe |
| pend_o | output | 1 | Eligible interrupt pending |
| ack_valid_o | output | 1 | Acknowledge result valid, one cycle |
| ack_vec_o | output | VEC_W | Vector of the granted request |

## Verification
`pend_o` is combinational on the registered pending bits and on the current priority and mode inputs. It is due in the same cycle as an input change, and a new request shows up one edge after its pulse. The vector and valid pulse are due exactly one edge after the acknowledge cycle. The pending clear and table updates are visible from that same edge. A behavioural model in the bench advances on each rising edge from the same sampled inputs. Outputs are compared 2 ns after every rising edge, while the inputs still hold the values that were driven on the previous falling edge, so every result is read in its due cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned DEF_NUM_LVL  = 8;
  localparam int unsigned DEF_REQ_W    = 32;
  localparam int unsigned DEF_VEC_W    = 16;
  localparam int unsigned DEF_HMIN_LVL = 4;
  localparam int unsigned DEF_SW_BIT   = 31;
  localparam logic [15:0] DEF_SW_VEC   = 16'h00A0;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned REQ_W   = 32,
  parameter int unsigned SW_BIT  = 31,
  localparam int unsigned NSRC   = NUM_LVL * REQ_W,
  localparam int unsigned IDX_W  = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  set_i,
  input  logic [NUM_LVL-1:0] sw_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [NSRC-1:0]  pend_o
);
  logic [NSRC-1:0] sw_set, clr_vec, pend_q;

  // software requests land on a fixed line of levels 1 and up
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_sw
    for (genvar b = 0; b < REQ_W; b++) begin : g_bit
      if (l > 0 && b == SW_BIT) begin : g_on
        assign sw_set[l*REQ_W+b] = sw_i[l];
      end else begin : g_off
        assign sw_set[l*REQ_W+b] = 1'b0;
      end
    end
  end

  always_comb begin
    clr_vec = '0;
    if (clr_en_i) clr_vec[clr_idx_i] = 1'b1;
  end

  // new set beats same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_vec) | set_i | sw_set;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int unsigned NUM_LVL  = 8,
  parameter int unsigned REQ_W    = 32,
  parameter int unsigned HMIN_LVL = 4,
  localparam int unsigned NSRC    = NUM_LVL * REQ_W,
  localparam int unsigned LVL_W   = $clog2(NUM_LVL),
  localparam int unsigned BIT_W   = $clog2(REQ_W)
) (
  input  logic [NSRC-1:0]  pend_i,
  input  logic [NSRC-1:0]  mask_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic             restrict_i,
  output logic             hit_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [BIT_W-1:0] bit_o
);
  logic            use_mask;
  logic [NSRC-1:0] cand;
  logic [REQ_W-1:0] lvl_req [NUM_LVL];
  logic [REQ_W-1:0] sel;

  assign use_mask = restrict_i && (int'(ipl_i) >= int'(HMIN_LVL));
  assign cand     = use_mask ? (pend_i & mask_i) : pend_i;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    assign lvl_req[l] = (l > int'(ipl_i)) ? cand[l*REQ_W +: REQ_W] : '0;
  end

  // ascending scan: a higher level overwrites a lower one
  always_comb begin
    hit_o = 1'b0;
    lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (|lvl_req[l]) begin
        hit_o = 1'b1;
        lvl_o = LVL_W'(l);
      end
    end
  end

  assign sel = lvl_req[lvl_o];

  // descending scan: a lower line overwrites a higher one
  always_comb begin
    bit_o = '0;
    for (int b = REQ_W - 1; b >= 0; b--) begin
      if (sel[b]) bit_o = BIT_W'(b);
    end
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned REQ_W   = 32,
  parameter int unsigned VEC_W   = 16,
  localparam int unsigned NSRC   = NUM_LVL * REQ_W,
  localparam int unsigned IDX_W  = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [VEC_W-1:0] wvec_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [VEC_W-1:0] rvec_o
);
  logic [VEC_W-1:0] mem_q [NSRC];
  logic [VEC_W-1:0] wr_aligned;

  assign wr_aligned = wvec_i & ~VEC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSRC; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wr_aligned;
    end
  end

  assign rvec_o = mem_q[ridx_i];
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_LVL  = DEF_NUM_LVL,
  parameter int unsigned REQ_W    = DEF_REQ_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned HMIN_LVL = DEF_HMIN_LVL,
  parameter int unsigned SW_BIT   = DEF_SW_BIT,
  parameter logic [VEC_W-1:0] SW_VEC = VEC_W'(DEF_SW_VEC)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_LVL*REQ_W-1:0]     req_set_i,
  input  logic [NUM_LVL-1:0]           sw_req_i,
  input  logic [$clog2(NUM_LVL)-1:0]   ipl_i,
  input  logic                         restrict_i,
  input  logic [NUM_LVL*REQ_W-1:0]     int_mask_i,
  input  logic                         tbl_we_i,
  input  logic [$clog2(NUM_LVL)-1:0]   tbl_lvl_i,
  input  logic [$clog2(REQ_W)-1:0]     tbl_bit_i,
  input  logic [VEC_W-1:0]             tbl_vec_i,
  input  logic [NUM_LVL*REQ_W-1:0]     ovr_en_i,
  input  logic [VEC_W-1:0]             ovr_vec_i,
  input  logic                         ack_i,
  output logic                         pend_o,
  output logic                         ack_valid_o,
  output logic [VEC_W-1:0]             ack_vec_o
);
  localparam int unsigned NSRC  = NUM_LVL * REQ_W;
  localparam int unsigned LVL_W = $clog2(NUM_LVL);
  localparam int unsigned BIT_W = $clog2(REQ_W);
  localparam int unsigned IDX_W = LVL_W + BIT_W; // REQ_W is a power of two

  logic [NSRC-1:0]  pend_q;
  logic             hit;
  logic [LVL_W-1:0] win_lvl;
  logic [BIT_W-1:0] win_bit;
  logic [IDX_W-1:0] win_idx;
  logic [VEC_W-1:0] tbl_rd, vec_sel;
  logic             ack_valid_q;
  logic [VEC_W-1:0] ack_vec_q;

  assign win_idx = {win_lvl, win_bit};

  irq_pend_bank #(.NUM_LVL(NUM_LVL), .REQ_W(REQ_W), .SW_BIT(SW_BIT)) u_pend (
    .clk_i, .rst_ni,
    .set_i     (req_set_i),
    .sw_i      (sw_req_i),
    .clr_en_i  (ack_i & hit),
    .clr_idx_i (win_idx),
    .pend_o    (pend_q)
  );

  irq_prio_scan #(.NUM_LVL(NUM_LVL), .REQ_W(REQ_W), .HMIN_LVL(HMIN_LVL)) u_scan (
    .pend_i     (pend_q),
    .mask_i     (int_mask_i),
    .ipl_i      (ipl_i),
    .restrict_i (restrict_i),
    .hit_o      (hit),
    .lvl_o      (win_lvl),
    .bit_o      (win_bit)
  );

  irq_vec_table #(.NUM_LVL(NUM_LVL), .REQ_W(REQ_W), .VEC_W(VEC_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i   (tbl_we_i),
    .widx_i ({tbl_lvl_i, tbl_bit_i}),
    .wvec_i (tbl_vec_i),
    .ridx_i (win_idx),
    .rvec_o (tbl_rd)
  );

  always_comb begin
    if (ovr_en_i[win_idx])                              vec_sel = ovr_vec_i;
    else if (int'(win_bit) == SW_BIT && win_lvl != '0)  vec_sel = SW_VEC;
    else                                                vec_sel = tbl_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_q <= 1'b0;
      ack_vec_q   <= '0;
    end else begin
      ack_valid_q <= ack_i;
      if (ack_i) ack_vec_q <= hit ? vec_sel : '0;
    end
  end

  assign pend_o      = hit;
  assign ack_valid_o = ack_valid_q;
  assign ack_vec_o   = ack_vec_q;
endmodule

// File: rtl/irq_vec_arb_chk.sv
module irq_vec_arb_chk #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned REQ_W   = 32,
  parameter int unsigned VEC_W   = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       ack_i,
  input logic [$clog2(NUM_LVL)-1:0] ipl_i,
  input logic [NUM_LVL*REQ_W-1:0]   req_set_i,
  input logic [NUM_LVL-1:0]         sw_req_i,
  input logic [NUM_LVL*REQ_W-1:0]   pend_q,
  input logic                       pend_o,
  input logic                       ack_valid_o,
  input logic [VEC_W-1:0]           ack_vec_o
);
  p_ack_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ack_valid_o);

  p_no_spurious_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !ack_valid_o);

  p_idle_zero_vec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !pend_o) |=> (ack_vec_o == '0));

  p_top_ipl_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ipl_i) == NUM_LVL - 1) |-> !pend_o);

  p_grant_clears_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_o && req_set_i == '0 && sw_req_i == '0)
    |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  p_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ($countones(pend_q) >= $countones($past(pend_q))));
endmodule

bind irq_vec_arb irq_vec_arb_chk #(.NUM_LVL(NUM_LVL), .REQ_W(REQ_W), .VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .ipl_i       (ipl_i),
  .req_set_i   (req_set_i),
  .sw_req_i    (sw_req_i),
  .pend_q      (pend_q),
  .pend_o      (pend_o),
  .ack_valid_o (ack_valid_o),
  .ack_vec_o   (ack_vec_o)
);

// File: tb/irq_vec_arb_tb.sv
`timescale 1ns/1ps
module irq_vec_arb_tb;
  localparam int NL = 8, RW = 32, NS = NL * RW, THR = 4, SWB = 31;
  localparam logic [15:0] SWV = 16'h00A0;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] req_set = '0, mask = '0, ovr_en = '0;
  logic [NL-1:0] sw_req = '0;
  logic [2:0] ipl = '0, tbl_lvl = '0;
  logic [4:0] tbl_bit = '0;
  logic restrict_m = 0, tbl_we = 0, ack = 0;
  logic [15:0] tbl_vec = '0, ovr_vec = '0;
  logic pend_o, ack_valid_o;
  logic [15:0] ack_vec_o;

  int checks = 0, errors = 0;
  string tag = "R1 reset";

  always #5 clk = ~clk;

  irq_vec_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(req_set), .sw_req_i(sw_req),
    .ipl_i(ipl), .restrict_i(restrict_m), .int_mask_i(mask),
    .tbl_we_i(tbl_we), .tbl_lvl_i(tbl_lvl), .tbl_bit_i(tbl_bit), .tbl_vec_i(tbl_vec),
    .ovr_en_i(ovr_en), .ovr_vec_i(ovr_vec), .ack_i(ack),
    .pend_o(pend_o), .ack_valid_o(ack_valid_o), .ack_vec_o(ack_vec_o)
  );

  // reference model
  logic [NS-1:0] m_pend;
  logic [15:0] m_tbl [NS];
  logic m_valid;
  logic [15:0] m_vec;

  function automatic void find(output bit h, output int lv, output int bt);
    h = 0; lv = 0; bt = 0;
    for (int l = NL - 1; l >= 0; l--) begin
      if (!h && l > int'(ipl)) begin
        for (int b = 0; b < RW; b++) begin
          if (!h && m_pend[l*RW+b] && (!restrict_m || int'(ipl) < THR || mask[l*RW+b])) begin
            h = 1; lv = l; bt = b;
          end
        end
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit h; int lv, bt;
    if (!rst_n) begin
      m_pend = '0; m_valid = 0; m_vec = '0;
      for (int i = 0; i < NS; i++) m_tbl[i] = '0;
    end else begin
      if (ack) begin
        find(h, lv, bt);
        m_valid = 1;
        if (h) begin
          if (ovr_en[lv*RW+bt])       m_vec = ovr_vec;
          else if (bt == SWB && lv > 0) m_vec = SWV;
          else                        m_vec = m_tbl[lv*RW+bt];
          m_pend[lv*RW+bt] = 0;
        end else m_vec = '0;
      end else m_valid = 0;
      m_pend = m_pend | req_set;
      for (int l = 1; l < NL; l++) if (sw_req[l]) m_pend[l*RW+SWB] = 1;
      if (tbl_we) m_tbl[int'(tbl_lvl)*RW+int'(tbl_bit)] = tbl_vec & 16'hFFFE;
    end
  end

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit h; int lv, bt;
    #2;
    if (rst_n) begin
      find(h, lv, bt);
      check("pend_o", 16'(pend_o), 16'(h));
      check("ack_valid_o", 16'(ack_valid_o), 16'(m_valid));
      if (m_valid) check("ack_vec_o", ack_vec_o, m_vec);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_req(input int l, input int b);
    req_set[l*RW+b] = 1; tick(); req_set = '0;
  endtask
  task automatic wr_tbl(input int l, input int b, input logic [15:0] v);
    tbl_we = 1; tbl_lvl = 3'(l); tbl_bit = 5'(b); tbl_vec = v; tick(); tbl_we = 0;
  endtask
  task automatic do_ack();
    ack = 1; tick(); ack = 0; tick();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    tag = "R1 reset";
    check("reset pend_o", 16'(pend_o), 16'h0);
    check("reset valid", 16'(ack_valid_o), 16'h0);

    tag = "R8 table write";
    wr_tbl(3, 5, 16'h0105); wr_tbl(3, 9, 16'h0208); wr_tbl(6, 2, 16'h0302);
    wr_tbl(2, 0, 16'h0410); wr_tbl(6, 31, 16'h0555); wr_tbl(4, 7, 16'h0777);
    tick();

    tag = "R4 lowest line wins";
    req_set[3*RW+9] = 1; req_set[3*RW+5] = 1; tick(); req_set = '0;
    tick(); do_ack();
    tag = "R5 second grant";
    do_ack();

    tag = "R3 highest level wins";
    pulse_req(2, 0); pulse_req(6, 2); tick();
    do_ack(); do_ack();

    tag = "R6 ack with nothing eligible";
    do_ack();

    tag = "R2 priority compare";
    pulse_req(6, 2); ipl = 3'd6; tick(2);
    ipl = 3'd7; tick(2);
    ipl = 3'd5; tick(2);
    tag = "R6 ack masked by priority";
    ipl = 3'd6; do_ack();
    ipl = 3'd0; do_ack();

    tag = "R7 restricted mode";
    restrict_m = 1; ipl = 3'd4; pulse_req(6, 2); tick(2);
    mask[6*RW+2] = 1; tick(2);
    mask = '0; ipl = 3'd3; tick(2);
    ipl = 3'd4; restrict_m = 0; tick(2);
    restrict_m = 1; do_ack();
    ipl = 3'd0; restrict_m = 0; do_ack();

    tag = "R9 override vector";
    pulse_req(4, 7); ovr_en[4*RW+7] = 1; ovr_vec = 16'h1233;
    do_ack(); ovr_en = '0;

    tag = "R10 software request";
    sw_req = 8'b0000_1001; tick(); sw_req = '0; tick();
    do_ack(); do_ack();
    sw_req = 8'b0100_0000; tick(); sw_req = '0;
    do_ack();

    tag = "R11 set during grant";
    pulse_req(5, 3); tick();
    ack = 1; req_set[5*RW+3] = 1; tick(); ack = 0; req_set = '0; tick(2);
    do_ack();

    tag = "R5 random mix";
    for (int c = 0; c < 2000; c++) begin
      req_set = '0; sw_req = '0;
      if ($urandom_range(0, 2) == 0) req_set[$urandom_range(0, NS-1)] = 1;
      if ($urandom_range(0, 9) == 0) sw_req[$urandom_range(0, NL-1)] = 1;
      ack = ($urandom_range(0, 3) == 0);
      ipl = 3'($urandom_range(0, 7));
      restrict_m = $urandom_range(0, 1) == 1;
      mask = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      ovr_en = '0;
      if ($urandom_range(0, 3) == 0) ovr_en = mask;
      ovr_vec = 16'($urandom);
      tbl_we = ($urandom_range(0, 4) == 0);
      tbl_lvl = 3'($urandom); tbl_bit = 5'($urandom); tbl_vec = 16'($urandom);
      tick();
    end
    req_set = '0; sw_req = '0; ack = 0; tbl_we = 0;
    tick(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule